// File: doc/BRIEF.md
# Double-Buffered Multichannel Code Register Bank

This block holds sixteen 8-bit codes for a row of converter ladders. The codes sit behind a parallel bus of the kind a small microprocessor drives. Each channel has two stages. The first is a staging register that the bus writes one channel at a time. The second is an output register, and the sixteen output registers drive the ladders. A single load strobe, valid only while the enable strobe is also low, copies every staging register into its output register in the same clock cycle. Software can therefore prepare any set of channels and then change all outputs at one instant.

A fast system clock samples every bus pin through a two-stage synchronizer. All strobe levels are evaluated in that clock domain. The data port is split into an input, an output and an output enable, so that a pad ring can build the bidirectional pin. The output enable is high only while a readback of a staging register is selected. An active-low reset asserts asynchronously, releases in step with the clock, and clears every register of both stages.

Top module: `chan_code_bank`

## Requirements
- R1: While reset is asserted, and directly after it is released, all sixteen output codes read zero and the data output enable is low. Reset clears the output codes without waiting for a clock edge.
- R2: While chip select, the read/write select and the enable strobe are all low (read/write low means write), the staging register picked by the address takes the data input. The value present when the enable strobe returns high stays held. Address value A selects channel A, with the address bit 0 as the least significant bit.
- R3: Writing a staging register leaves every output code unchanged until a load qualified by the enable strobe takes place.
- R4: While the load strobe and the enable strobe are both low, every output register takes its staging register. All sixteen codes change in the same clock cycle.
- R5: With chip select high, a load with the enable strobe low still updates the output codes, but no staging register changes, whatever the address and data inputs carry.
- R6: With read/write high, chip select low, and both the enable and load strobes high, the data output enable goes high and the data output shows the staging register picked by the address. A change of address shows up within a few clock cycles.
- R7: With chip select high, or with read/write low, the data output enable is low.
- R8: The load strobe low while the enable strobe is high leaves every output code unchanged.
- R9: Asserting reset in the middle of operation clears both the staging registers and the output registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Channel address, bit 0 least significant |
| bus_wdata | input | 8 | Data port, input side |
| bus_rdata | output | 8 | Data port, output side (readback) |
| bus_rdata_oe | output | 1 | Drive enable for the data port output side |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_rd | input | 1 | Read/write select: 1 = read, 0 = write |
| bus_stb_n | input | 1 | Enable strobe, active low |
| bus_load_n | input | 1 | Broadcast load strobe, active low |
| code_out | output | 128 | Sixteen output codes, channel n in bits 8n+7..8n |

## Verification
The staging registers are filled with two patterns. The first is an address-dependent value that differs on every channel. The second is a walking single bit. Readback of every channel under both patterns separates a correct address decode from swapped or stuck address bits. Output codes are compared before and after each load, which separates the staging stage from the output stage. Loads are also tried with chip select high and with the enable strobe high, and those runs show whether a load gating term is missing or whether a staging register leaks a stray write.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int unsigned CCB_CH = 16;
  localparam int unsigned CCB_AW = 4;
  localparam int unsigned CCB_DW = 8;

  typedef logic [CCB_DW-1:0] code_t;
endpackage

// File: rtl/ccb_bus_sync.sv
module ccb_bus_sync #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rst_sync_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sel_n_i,
  input  logic          rd_i,
  input  logic          stb_n_i,
  input  logic          load_n_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          sel_n_o,
  output logic          rd_o,
  output logic          stb_n_o,
  output logic          load_n_o
);
  localparam int unsigned SW = AW + DW + 4;
  localparam logic [SW-1:0] IDLE_VAL = {{(AW+DW){1'b0}}, 1'b1, 1'b0, 1'b1, 1'b1};

  logic [1:0]    rst_pipe;
  logic [SW-1:0] raw_vec;
  logic [SW-1:0] stage1_q;
  logic [SW-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign raw_vec = {addr_i, wdata_i, sel_n_i, rd_i, stb_n_i, load_n_i};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stage1_q <= IDLE_VAL;
      stage2_q <= IDLE_VAL;
    end else begin
      stage1_q <= raw_vec;
      stage2_q <= stage1_q;
    end
  end

  assign {addr_o, wdata_o, sel_n_o, rd_o, stb_n_o, load_n_o} = stage2_q;
endmodule

// File: rtl/ccb_input_bank.sv
module ccb_input_bank
  import ccb_pkg::*;
#(
  parameter int unsigned CH = 16,
  parameter int unsigned AW = 4
) (
  input  logic                clk,
  input  logic                rst_sync_n,
  input  logic [AW-1:0]       addr,
  input  code_t               wdata,
  input  logic                sel_n,
  input  logic                rd,
  input  logic                stb_n,
  output code_t [CH-1:0]      stage_q
);
  logic          wr_open;
  logic [CH-1:0] ch_we;
  code_t [CH-1:0] stage_d;

  assign wr_open = !sel_n && !rd && !stb_n;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign ch_we[i] = wr_open && (addr == AW'(i));

    always_comb begin
      stage_d[i] = stage_q[i];
      if (ch_we[i]) stage_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) stage_q[i] <= '0;
      else             stage_q[i] <= stage_d[i];
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sel_n || !stb_n && rd || stb_n || addr != AW'(i)) |=> $stable(stage_q[i])); // R5
  end
endmodule

// File: rtl/ccb_output_bank.sv
module ccb_output_bank
  import ccb_pkg::*;
#(
  parameter int unsigned CH = 16
) (
  input  logic           clk,
  input  logic           rst_sync_n,
  input  logic           stb_n,
  input  logic           load_n,
  input  code_t [CH-1:0] stage_q,
  output code_t [CH-1:0] out_q
);
  logic           xfer_en;
  code_t [CH-1:0] out_d;

  assign xfer_en = !load_n && !stb_n;

  always_comb begin
    out_d = out_q;
    if (xfer_en) out_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= '0;
    else             out_q <= out_d;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_n || stb_n) |=> $stable(out_q)); // R3
  AST_LOAD_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_n && stb_n) |=> $stable(out_q)); // R8
endmodule

// File: rtl/ccb_readback.sv
module ccb_readback
  import ccb_pkg::*;
#(
  parameter int unsigned CH = 16,
  parameter int unsigned AW = 4
) (
  input  logic           clk,
  input  logic           rst_sync_n,
  input  logic [AW-1:0]  addr,
  input  logic           sel_n,
  input  logic           rd,
  input  logic           stb_n,
  input  logic           load_n,
  input  code_t [CH-1:0] stage_q,
  output code_t          rdata_q,
  output logic           oe_q
);
  logic  rd_sel;
  code_t rdata_d;
  logic  oe_d;

  assign rd_sel = rd && !sel_n && stb_n && load_n;

  always_comb begin
    oe_d    = rd_sel;
    rdata_d = rdata_q;
    if (rd_sel) rdata_d = stage_q[addr];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      oe_q    <= oe_d;
      rdata_q <= rdata_d;
    end
  end

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_n || !rd) |=> !oe_q); // R7
  AST_OE_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oe_q && $past(oe_q) && $stable(addr) && $past(rd_sel)) |-> rdata_q == $past(stage_q[addr])); // R6
endmodule

// File: rtl/chan_code_bank.sv
module chan_code_bank
  import ccb_pkg::*;
#(
  parameter int unsigned CH = CCB_CH,
  parameter int unsigned AW = CCB_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [CCB_DW-1:0]  bus_wdata,
  output logic [CCB_DW-1:0]  bus_rdata,
  output logic               bus_rdata_oe,
  input  logic               bus_sel_n,
  input  logic               bus_rd,
  input  logic               bus_stb_n,
  input  logic               bus_load_n,
  output logic [CH*CCB_DW-1:0] code_out
);
  logic           rst_sync_n;
  logic [AW-1:0]  s_addr;
  code_t          s_wdata;
  logic           s_sel_n, s_rd, s_stb_n, s_load_n;
  code_t [CH-1:0] stage_q;
  code_t [CH-1:0] out_q;
  code_t          rdata_q;
  logic           oe_q;

  ccb_bus_sync #(.AW(AW), .DW(CCB_DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .sel_n_i(bus_sel_n),
    .rd_i(bus_rd), .stb_n_i(bus_stb_n), .load_n_i(bus_load_n),
    .addr_o(s_addr), .wdata_o(s_wdata), .sel_n_o(s_sel_n),
    .rd_o(s_rd), .stb_n_o(s_stb_n), .load_n_o(s_load_n)
  );

  ccb_input_bank #(.CH(CH), .AW(AW)) u_in (
    .clk(clk), .rst_sync_n(rst_sync_n), .addr(s_addr), .wdata(s_wdata),
    .sel_n(s_sel_n), .rd(s_rd), .stb_n(s_stb_n), .stage_q(stage_q)
  );

  ccb_output_bank #(.CH(CH)) u_out (
    .clk(clk), .rst_sync_n(rst_sync_n), .stb_n(s_stb_n), .load_n(s_load_n),
    .stage_q(stage_q), .out_q(out_q)
  );

  ccb_readback #(.CH(CH), .AW(AW)) u_rb (
    .clk(clk), .rst_sync_n(rst_sync_n), .addr(s_addr), .sel_n(s_sel_n),
    .rd(s_rd), .stb_n(s_stb_n), .load_n(s_load_n), .stage_q(stage_q),
    .rdata_q(rdata_q), .oe_q(oe_q)
  );

  assign code_out     = out_q;
  assign bus_rdata    = rdata_q;
  assign bus_rdata_oe = oe_q;

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (code_out == '0 && !bus_rdata_oe)); // R1
endmodule

// File: tb/chan_code_bank_bench.sv
module chan_code_bank_bench;
  typedef struct {
    int        kind;   // 0 = output code, 1 = readback data, 2 = output enable
    int        ch;
    logic [7:0] val;
    string     req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   bus_addr;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic         bus_rdata_oe;
  logic         bus_sel_n, bus_rd, bus_stb_n, bus_load_n;
  logic [127:0] code_out;

  exp_t       exp_q[$];
  logic [7:0] mdl_stage [16];
  logic [7:0] mdl_out   [16];
  int   n_checks = 0;
  int   n_bad    = 0;
  bit   sample_req = 1'b0;
  bit   finished   = 1'b0;

  always #2 clk = ~clk;

  chan_code_bank u_chan_code_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_sel_n(bus_sel_n),
    .bus_rd(bus_rd), .bus_stb_n(bus_stb_n), .bus_load_n(bus_load_n),
    .code_out(code_out)
  );

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sample_req) begin
        while (exp_q.size() > 0) begin
          exp_t e;
          logic [7:0] act;
          e = exp_q.pop_front();
          case (e.kind)
            0:       act = code_out[e.ch*8 +: 8];
            1:       act = bus_rdata;
            default: act = {7'd0, bus_rdata_oe};
          endcase
          n_checks++;
          if (act !== e.val) begin
            n_bad++;
            $display("FAIL %s kind=%0d ch=%0d actual=%02h expected=%02h",
                     e.req, e.kind, e.ch, act, e.val);
          end
        end
        sample_req = 1'b0;
      end
    end
  end

  task automatic push(input int kind, input int ch, input logic [7:0] val, input string req);
    exp_t e;
    e.kind = kind; e.ch = ch; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic flush();
    sample_req = 1'b1;
    wait (sample_req == 1'b0);
  endtask

  task automatic expect_codes(input string req);
    for (int i = 0; i < 16; i++) push(0, i, mdl_out[i], req);
    flush();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int ch, input logic [7:0] v);
    @(negedge clk);
    bus_addr = 4'(ch); bus_wdata = v; bus_rd = 1'b0; bus_sel_n = 1'b0;
    idle(3);
    bus_stb_n = 1'b0;
    idle(4);
    bus_stb_n = 1'b1;
    idle(4);
    bus_sel_n = 1'b1;
    bus_wdata = 8'hEE;
    idle(3);
    mdl_stage[ch] = v;
  endtask

  task automatic bus_load();
    @(negedge clk);
    bus_load_n = 1'b0; bus_stb_n = 1'b0;
    idle(5);
    bus_load_n = 1'b1; bus_stb_n = 1'b1;
    idle(5);
    for (int i = 0; i < 16; i++) mdl_out[i] = mdl_stage[i];
  endtask

  task automatic readback_all(input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      bus_addr = 4'(i);
      idle(5);
      push(2, i, 8'h01, req);
      push(1, i, mdl_stage[i], req);
      flush();
    end
    bus_sel_n = 1'b1; bus_rd = 1'b0;
    idle(5);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_sel_n = 1'b1; bus_rd = 1'b0;
    bus_stb_n = 1'b1; bus_load_n = 1'b1;
    for (int i = 0; i < 16; i++) begin mdl_stage[i] = '0; mdl_out[i] = '0; end
    idle(4);
    push(2, 0, 8'h00, "R1"); expect_codes("R1");
    rst_n = 1'b1;
    idle(6);
    push(2, 0, 8'h00, "R1"); expect_codes("R1");

    // pattern A: distinct per-channel values
    for (int i = 0; i < 16; i++) bus_write(i, 8'((i * 17) ^ 8'h5A));
    expect_codes("R3");
    readback_all("R2");

    // readback gating
    @(negedge clk);
    bus_rd = 1'b1; bus_sel_n = 1'b1; bus_addr = 4'd7;
    idle(6);
    push(2, 0, 8'h00, "R7"); flush();
    bus_rd = 1'b0; bus_sel_n = 1'b0;
    idle(6);
    push(2, 0, 8'h00, "R7"); flush();
    bus_sel_n = 1'b1;
    idle(4);

    // load without enable strobe
    @(negedge clk);
    bus_load_n = 1'b0;
    idle(6);
    bus_load_n = 1'b1;
    idle(4);
    expect_codes("R8");

    bus_load();
    expect_codes("R4");
    readback_all("R6");

    // stage ch3 with a new value, then load with chip select high and junk on the bus
    bus_write(3, 8'hC3);
    expect_codes("R3");
    @(negedge clk);
    bus_sel_n = 1'b1; bus_rd = 1'b0; bus_addr = 4'd3; bus_wdata = 8'hFF;
    bus_load_n = 1'b0; bus_stb_n = 1'b0;
    idle(6);
    bus_load_n = 1'b1; bus_stb_n = 1'b1;
    idle(5);
    for (int i = 0; i < 16; i++) mdl_out[i] = mdl_stage[i];
    expect_codes("R5");
    readback_all("R5");

    // pattern B: walking one
    for (int i = 0; i < 16; i++) bus_write(i, 8'(1 << (i % 8)) ^ (i >= 8 ? 8'hFF : 8'h00));
    bus_load();
    expect_codes("R4");
    readback_all("R2");

    // reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 16; i++) begin mdl_stage[i] = '0; mdl_out[i] = '0; end
    expect_codes("R9");
    idle(3);
    rst_n = 1'b1;
    idle(6);
    expect_codes("R9");
    readback_all("R9");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule